// File: doc/BRIEF.md
# Transmit Descriptor Chain DMA

This block moves outgoing frames from memory to a byte stream by following a linked list of descriptors. Software first loads a start pointer and then writes the control enable bit. From that point the engine reads one descriptor at a time, streams the frame bytes, and marks the descriptor as consumed. It keeps going until it reaches a descriptor that is already marked empty.

Each descriptor takes three consecutive little-endian 32-bit words. Word 0 holds the frame buffer byte address, word 1 holds the size and flags, and word 2 holds the address of the next descriptor. Memory is reached through a single-word valid/ready port, which is used for reads and for the one write-back per frame. Frame bytes normally leave on the line output. A loopback setting sends them to a receive-side output instead. The status logic outside this block is given two one-cycle events: frame sent, and underrun at the end of a chain.

Top module: `tx_dma`

## Requirements
- R1: A control write with the enable bit set (`ctl_en_i`=1) starts a walk only when `cfg_tx_en_i` is 1. `enable_o` takes the written bit on any control write made while idle. Control writes made during a walk are ignored, and `enable_o` stays 1.
- R2: A write to the start pointer clears address bits 1:0. The first memory access of a walk reads the aligned start pointer.
- R3: The descriptor words are read at offsets +0 (buffer byte address), +4 (size word) and +8 (next pointer). Bits 1:0 of the next pointer are cleared before it is followed.
- R4: If bit 31 of the size word is 1, the descriptor is empty. The walk stops there without emitting a byte and without writing to that descriptor. `underrun_o` pulses for one cycle and `enable_o` is 0 in that same cycle.
- R5: The frame length is size word bits 10:0, which allows 0 to 2047 bytes. Bits 30:11 have no effect on the length.
- R6: Frame bytes leave in ascending address order from any byte alignment. Byte address a is taken from bits 8*(a mod 4)+7 : 8*(a mod 4) of the word at a with bits 1:0 cleared. `last` is 1 on the final byte of the frame only.
- R7: After the final byte, the engine writes the original size word with bit 31 set back to offset +4. `sent_o` then pulses for one cycle, and the walk continues at the next pointer.
- R8: `cfg_loopback_i` is sampled once per frame, when the next pointer is read. If it is 1, the whole frame goes out on the loopback output and nothing goes out on the line output. If it is 0, the opposite holds.
- R9: A frame of length 0 emits no bytes but is still written back and still counted by `sent_o`.
- R10: A memory request, or an output byte whose ready input is low, holds its valid, address, data and last values unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_tx_en_i | input | 1 | MAC transmit enable |
| cfg_loopback_i | input | 1 | Divert frames to the loopback output |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_en_i | input | 1 | Enable bit of the control write |
| base_we_i | input | 1 | Start pointer write strobe |
| base_wdata_i | input | 32 | Start pointer write data |
| enable_o | output | 1 | Engine enable bit |
| mem_valid_o | output | 1 | Memory request valid |
| mem_write_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Word-aligned memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts request; read data valid |
| mem_rdata_i | input | 32 | Memory read data |
| line_valid_o | output | 1 | Line byte valid |
| line_data_o | output | 8 | Line byte |
| line_last_o | output | 1 | Final byte of frame on line |
| line_ready_i | input | 1 | Line sink ready |
| lb_valid_o | output | 1 | Loopback byte valid |
| lb_data_o | output | 8 | Loopback byte |
| lb_last_o | output | 1 | Final byte of frame on loopback |
| lb_ready_i | input | 1 | Loopback sink ready |
| sent_o | output | 1 | One-cycle frame sent event |
| underrun_o | output | 1 | One-cycle chain end event |

## Verification
The assertions assume three things about the inputs. The memory delivers read data in the same cycle it raises ready. Every chain reaches an empty descriptor. The stream sinks eventually accept. The bench memory model returns data combinationally from its array in every cycle, and it drops ready at random but never indefinitely. Each chain the bench builds ends in an explicit empty descriptor, and the bench also injects control writes while a walk is in progress and tries starting with transmit disabled.

// File: rtl/tx_dma_pkg.sv
package tx_dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_BUF,
    S_RD_SIZE,
    S_RD_NEXT,
    S_FETCH,
    S_STREAM,
    S_WB
  } state_e;
endpackage

// File: rtl/tx_dma_unpack.sv
module tx_dma_unpack #(
  parameter int DW     = 32,
  parameter int LANE_W = $clog2(DW / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DW-1:0]     word_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [7:0]        byte_o
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  // little-endian lane select
  assign byte_o = word_q[8*lane_i +: 8];
endmodule

// File: rtl/tx_dma_route.sv
module tx_dma_route (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_lb_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic       line_valid_o,
  output logic [7:0] line_data_o,
  output logic       line_last_o,
  input  logic       line_ready_i,
  output logic       lb_valid_o,
  output logic [7:0] lb_data_o,
  output logic       lb_last_o,
  input  logic       lb_ready_i
);
  assign line_valid_o = in_valid_i && !sel_lb_i;
  assign lb_valid_o   = in_valid_i &&  sel_lb_i;
  assign line_data_o  = in_data_i;
  assign lb_data_o    = in_data_i;
  assign line_last_o  = in_last_i && !sel_lb_i;
  assign lb_last_o    = in_last_i &&  sel_lb_i;
  assign in_ready_o   = sel_lb_i ? lb_ready_i : line_ready_i;

  p_one_path_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_valid_o && lb_valid_o));
  p_line_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o && !line_ready_i |=> line_valid_o && $stable(line_data_o) && $stable(line_last_o));
  p_lb_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lb_valid_o && !lb_ready_i |=> lb_valid_o && $stable(lb_data_o) && $stable(lb_last_o));
endmodule

// File: rtl/tx_dma.sv
module tx_dma
  import tx_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LEN_W     = 11,
  parameter int EMPTY_BIT = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_tx_en_i,
  input  logic          cfg_loopback_i,
  input  logic          ctl_we_i,
  input  logic          ctl_en_i,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_wdata_i,
  output logic          enable_o,
  output logic          mem_valid_o,
  output logic          mem_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          line_valid_o,
  output logic [7:0]    line_data_o,
  output logic          line_last_o,
  input  logic          line_ready_i,
  output logic          lb_valid_o,
  output logic [7:0]    lb_data_o,
  output logic          lb_last_o,
  input  logic          lb_ready_i,
  output logic          sent_o,
  output logic          underrun_o
);
  localparam int BW     = DW / 8;
  localparam int LANE_W = $clog2(BW);

  state_e           state_q;
  logic [AW-1:0]    base_q, cur_q, buf_q, next_q;
  logic [DW-1:0]    size_q;
  logic [LEN_W-1:0] rem_q;
  logic             en_q, lb_q, sent_q, und_q;
  logic             mem_hs, s_valid, s_ready, s_last, s_hs;
  logic [7:0]       s_data;

  assign mem_valid_o = (state_q != S_IDLE) && (state_q != S_STREAM);
  assign mem_write_o = (state_q == S_WB);
  assign mem_wdata_o = size_q | (DW'(1) << EMPTY_BIT);
  assign mem_hs      = mem_valid_o && mem_ready_i;

  always_comb begin
    case (state_q)
      S_RD_BUF:        mem_addr_o = cur_q;
      S_RD_SIZE, S_WB: mem_addr_o = cur_q + AW'(BW);
      S_RD_NEXT:       mem_addr_o = cur_q + AW'(2 * BW);
      S_FETCH:         mem_addr_o = {buf_q[AW-1:LANE_W], {LANE_W{1'b0}}};
      default:         mem_addr_o = '0;
    endcase
  end

  assign s_valid = (state_q == S_STREAM);
  assign s_last  = (rem_q == LEN_W'(1));
  assign s_hs    = s_valid && s_ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      cur_q   <= '0;
      buf_q   <= '0;
      next_q  <= '0;
      size_q  <= '0;
      rem_q   <= '0;
      en_q    <= 1'b0;
      lb_q    <= 1'b0;
      sent_q  <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      sent_q <= 1'b0;
      und_q  <= 1'b0;
      if (base_we_i) base_q <= {base_wdata_i[AW-1:LANE_W], {LANE_W{1'b0}}};
      case (state_q)
        S_IDLE: if (ctl_we_i) begin
          en_q <= ctl_en_i;
          if (ctl_en_i && cfg_tx_en_i) begin
            cur_q   <= base_q;
            state_q <= S_RD_BUF;
          end
        end
        S_RD_BUF: if (mem_hs) begin
          buf_q   <= AW'(mem_rdata_i);
          state_q <= S_RD_SIZE;
        end
        S_RD_SIZE: if (mem_hs) begin
          size_q <= mem_rdata_i;
          rem_q  <= mem_rdata_i[LEN_W-1:0];
          if (mem_rdata_i[EMPTY_BIT]) begin
            en_q    <= 1'b0;
            und_q   <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            state_q <= S_RD_NEXT;
          end
        end
        S_RD_NEXT: if (mem_hs) begin
          next_q  <= {mem_rdata_i[AW-1:LANE_W], {LANE_W{1'b0}}};
          lb_q    <= cfg_loopback_i;
          state_q <= (rem_q == '0) ? S_WB : S_FETCH;
        end
        S_FETCH: if (mem_hs) state_q <= S_STREAM;
        S_STREAM: if (s_hs) begin
          buf_q <= buf_q + AW'(1);
          rem_q <= rem_q - LEN_W'(1);
          if (s_last) state_q <= S_WB;
          else if (buf_q[LANE_W-1:0] == LANE_W'(BW - 1)) state_q <= S_FETCH;
        end
        S_WB: if (mem_hs) begin
          sent_q  <= 1'b1;
          cur_q   <= next_q;
          state_q <= S_RD_BUF;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign enable_o   = en_q;
  assign sent_o     = sent_q;
  assign underrun_o = und_q;

  tx_dma_unpack #(.DW(DW), .LANE_W(LANE_W)) u_unpack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (state_q == S_FETCH && mem_hs),
    .word_i (mem_rdata_i),
    .lane_i (buf_q[LANE_W-1:0]),
    .byte_o (s_data)
  );

  tx_dma_route u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_lb_i     (lb_q),
    .in_valid_i   (s_valid),
    .in_data_i    (s_data),
    .in_last_i    (s_last),
    .in_ready_o   (s_ready),
    .line_valid_o (line_valid_o),
    .line_data_o  (line_data_o),
    .line_last_o  (line_last_o),
    .line_ready_i (line_ready_i),
    .lb_valid_o   (lb_valid_o),
    .lb_data_o    (lb_data_o),
    .lb_last_o    (lb_last_o),
    .lb_ready_i   (lb_ready_i)
  );

  p_mem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_write_o) && $stable(mem_wdata_o));
  p_mem_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_addr_o[LANE_W-1:0] == '0);
  p_walk_needs_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> enable_o);
  p_underrun_clears_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> !enable_o);
  p_events_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sent_o && underrun_o));
  p_no_bytes_when_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_o |-> !line_valid_o && !lb_valid_o);
endmodule

// File: tb/tb_tx_dma.sv
module tb_tx_dma;
  localparam int MEM_WORDS = 2048;
  localparam int DESC0     = 32'h40;
  localparam int BUF0      = 32'h200;
  localparam int WD_LIMIT  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tx_en = 1'b0, cfg_lb = 1'b0, ctl_we = 1'b0, ctl_en = 1'b0, base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        enable, mem_valid, mem_write, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        line_valid, line_last, line_ready = 1'b0;
  logic        lb_valid, lb_last, lb_ready = 1'b0;
  logic [7:0]  line_data, lb_data;
  logic        sent, underrun;

  logic [31:0] mem [0:MEM_WORDS-1];
  logic [8:0]  exp_q[$], line_q[$], lb_q[$];
  int          n_checks = 0, n_fail = 0, cyc = 0;
  int          sent_cnt = 0, und_cnt = 0, mem_req_cnt = 0;
  logic [31:0] first_addr = '0;
  bit          first_pending = 1'b0;
  int          lens[8];

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr[12:2]];

  tx_dma dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_tx_en_i(cfg_tx_en), .cfg_loopback_i(cfg_lb),
    .ctl_we_i(ctl_we), .ctl_en_i(ctl_en), .base_we_i(base_we), .base_wdata_i(base_wdata),
    .enable_o(enable), .mem_valid_o(mem_valid), .mem_write_o(mem_write),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .line_valid_o(line_valid), .line_data_o(line_data),
    .line_last_o(line_last), .line_ready_i(line_ready), .lb_valid_o(lb_valid),
    .lb_data_o(lb_data), .lb_last_o(lb_last), .lb_ready_i(lb_ready),
    .sent_o(sent), .underrun_o(underrun)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // ready decided for the coming edge, then the transfer it completes is recorded
  always @(negedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected < %0d", cyc, WD_LIMIT);
      summary();
    end
    if (rst_n) begin
      if (sent) sent_cnt++;
      if (underrun) und_cnt++;
      mem_ready  = ($urandom % 4) != 0;
      line_ready = ($urandom % 3) != 0;
      lb_ready   = ($urandom % 3) != 0;
      if (mem_valid && mem_ready) begin
        mem_req_cnt++;
        if (first_pending) begin first_addr = mem_addr; first_pending = 1'b0; end
        if (mem_write) mem[mem_addr[12:2]] = mem_wdata;
      end
      if (line_valid && line_ready) line_q.push_back({line_last, line_data});
      if (lb_valid && lb_ready) lb_q.push_back({lb_last, lb_data});
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input bit en);
    @(negedge clk); ctl_we = 1'b1; ctl_en = en;
    @(negedge clk); ctl_we = 1'b0; ctl_en = 1'b0;
  endtask

  task automatic wr_base(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic put_byte(input int a, input logic [7:0] b);
    mem[a >> 2][8*(a % 4) +: 8] = b;
  endtask

  function automatic logic [31:0] junk_hi();
    return $urandom & 32'h7FFF_F800;
  endfunction

  // builds n frames (lens[]) plus an empty terminator, runs the walk, checks results
  task automatic run_case(input string tag, input int n, input bit lb, input bit mid_write);
    int          bufp = BUF0;
    logic [31:0] orig [8];
    logic [31:0] term;
    int          mism = 0;
    logic [8:0]  got;
    exp_q.delete(); line_q.delete(); lb_q.delete();
    for (int i = 0; i < n; i++) begin
      int d  = DESC0 + 16 * i;
      int ba = bufp + int'($urandom % 4);
      orig[i] = junk_hi() | 32'(lens[i]);
      mem[d >> 2]       = 32'(ba);
      mem[(d >> 2) + 1] = orig[i];
      mem[(d >> 2) + 2] = 32'(d + 16) | ($urandom % 4);
      for (int k = 0; k < lens[i]; k++) begin
        logic [7:0] b = 8'($urandom);
        put_byte(ba + k, b);
        exp_q.push_back({(k == lens[i] - 1), b});
      end
      bufp = ba + lens[i] + 4;
    end
    term = 32'h8000_0000 | junk_hi();
    mem[(DESC0 + 16 * n) >> 2]       = 32'(BUF0);
    mem[((DESC0 + 16 * n) >> 2) + 1] = term;
    mem[((DESC0 + 16 * n) >> 2) + 2] = 32'(DESC0);
    sent_cnt = 0; und_cnt = 0;
    cfg_lb = lb; cfg_tx_en = 1'b1;
    wr_base(32'(DESC0) | ($urandom % 4));
    first_pending = 1'b1;
    wr_ctl(1'b1);
    if (mid_write) begin
      repeat (20) @(negedge clk);
      wr_ctl(1'b0);
      check({tag, " R1 enable kept after write during walk"}, 32'(enable), 32'd1);
    end
    for (int t = 0; t < 40000 && enable; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    check({tag, " R2 first access at aligned start"}, first_addr, 32'(DESC0));
    check({tag, " R7 sent count"}, 32'(sent_cnt), 32'(n));
    check({tag, " R4 underrun count"}, 32'(und_cnt), 32'd1);
    check({tag, " R4 enable cleared"}, 32'(enable), 32'd0);
    check({tag, " R4 empty descriptor untouched"}, mem[((DESC0 + 16 * n) >> 2) + 1], term);
    for (int i = 0; i < n; i++)
      check({tag, " R7 size write-back"}, mem[((DESC0 + 16 * i) >> 2) + 1], orig[i] | 32'h8000_0000);
    // R3 R5 R6 R9 R10: byte order, counts and last markers
    if (lb) check({tag, " R8 line silent"}, 32'(line_q.size()), 32'd0);
    else    check({tag, " R8 loopback silent"}, 32'(lb_q.size()), 32'd0);
    check({tag, " R5 R9 byte count"}, 32'(lb ? lb_q.size() : line_q.size()), 32'(exp_q.size()));
    for (int i = 0; i < exp_q.size(); i++) begin
      got = lb ? (i < lb_q.size() ? lb_q[i] : 9'h1FF) : (i < line_q.size() ? line_q[i] : 9'h1FF);
      if (got !== exp_q[i] && mism == 0)
        $display("  first mismatch at byte %0d: got 0x%0h exp 0x%0h", i, got, exp_q[i]);
      if (got !== exp_q[i]) mism++;
    end
    check({tag, " R6 R10 byte data and last"}, 32'(mism), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    void'($urandom(32'd7117));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset enable", 32'(enable), 32'd0);
    check("R10 reset mem_valid", 32'(mem_valid), 32'd0);
    check("R6 reset stream valid", 32'(line_valid | lb_valid), 32'd0);

    // R1: start blocked while transmit disabled
    lens[0] = 5;
    mem[DESC0 >> 2] = 32'(BUF0); mem[(DESC0 >> 2) + 1] = 32'd5; mem[(DESC0 >> 2) + 2] = 32'(DESC0 + 16);
    mem[(DESC0 + 20) >> 2] = 32'h8000_0000;
    cfg_tx_en = 1'b0;
    wr_base(32'(DESC0));
    mem_req_cnt = 0; sent_cnt = 0;
    wr_ctl(1'b1);
    repeat (40) @(negedge clk);
    check("R1 no access with tx disabled", 32'(mem_req_cnt), 32'd0);
    check("R1 enable bit stored", 32'(enable), 32'd1);
    cfg_tx_en = 1'b1;
    repeat (20) @(negedge clk);
    check("R1 tx enable alone does not start", 32'(mem_req_cnt), 32'd0);
    wr_ctl(1'b0);
    check("R1 enable cleared by write", 32'(enable), 32'd0);

    run_case("empty-first", 0, 1'b0, 1'b0);
    lens[0] = 1; lens[1] = 4; lens[2] = 5;
    run_case("short", 3, 1'b0, 1'b0);
    lens[0] = 0; lens[1] = 3;
    run_case("R9 zero-len", 2, 1'b0, 1'b0);
    lens[0] = 7; lens[1] = 2;
    run_case("R8 loopback", 2, 1'b1, 1'b0);
    lens[0] = 2047;
    run_case("R5 max-len", 1, 1'b0, 1'b0);
    lens[0] = 120; lens[1] = 9;
    run_case("R1 busy-write", 2, 1'b0, 1'b1);
    for (int it = 0; it < 8; it++) begin
      int n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) lens[i] = ($urandom % 5 == 0) ? 0 : int'($urandom % 200);
      run_case("R3 random", n, 1'($urandom % 2), 1'b0);
    end
    summary();
  end
endmodule